// File: doc/BRIEF.md
# Indexed-Port Calendar Clock

This block is a small calendar clock register file that software reaches through two byte-wide ports. A write to the index port picks one register. Later accesses to the data port then read or write the register that was picked. The register file holds seven time fields:

- seconds
- minutes
- hour
- day of week
- day of month
- month
- year

Four control registers are also decoded. They accept writes but have no effect.

A periodic tick input drives two things. Each tick raises a one-cycle interrupt pulse. Each tick also steps a 1024-to-1 prescaler, and when the prescaler wraps the seconds field advances. Only seconds count on their own, and they roll from 59 back to 0. The other fields change only through the data port.

The month and the year are stored with an offset from the value seen at the port:

- The month is stored zero-based.
- The year is stored with 52 added.

The data port undoes both offsets, so software sees the value it wrote. An access through an index that decodes to nothing returns zero and sets a sticky error flag.

Top module: `rtc_indexed_regs`

## Requirements
- R1: A pulse on `idx_wr` latches `wdata` as the register index. Data-port accesses go to the register at the latched index. The index resets to 0x00, which selects no register. Index codes:
  - 0x10 seconds
  - 0x11 minutes
  - 0x12 hour
  - 0x13 day of week
  - 0x14 day of month
  - 0x15 month
  - 0x16 year
  - 0x20 to 0x23 the four control registers
- R2: Each cycle with `tick` high gives `irq` high in the following cycle, for exactly one cycle per tick. Each tick also steps a prescaler count modulo 1024.
- R3: Seconds advance by one on the tick that finds the prescaler at 1023, and at no other time without a write. A value of 59 or above advances to 0.
- R4: A data-port write to seconds, minutes, hour, day of week or day of month stores the byte unchanged. A read returns it. All fields reset to a stored value of 0.
- R5: The month is stored as the written value minus 1 and read back as the stored value plus 1, so it reads 1 after reset.
- R6: The year is stored as the written value plus 52 and read back as the stored value minus 52, modulo 256, so it reads 0xCC after reset.
- R7: Writes to the four control indices leave every time field unchanged and raise no error. Reads of them return 0x00.
- R8: A data-port read or write at an undecoded index sets `err` from the next cycle until reset. Such a read returns 0x00, and such a write changes no field.
- R9: A read of day of month returns that field only, not the month field beside it.
- R10: A seconds write in the same cycle as the 1024th tick takes priority: seconds take the written value, and the prescaler still wraps to 0.
- R11: `rdata` is 0x00 whenever `data_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic tick, one cycle per tick |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| wdata | input | 8 | Write byte for both ports |
| rdata | output | 8 | Data-port read byte, valid while `data_rd` is high |
| irq | output | 1 | Periodic interrupt pulse |
| err | output | 1 | Sticky flag for access to an undecoded index |

## Verification
A software write to seconds and the prescaler's own seconds advance can land on the same clock edge. The bench provokes this in three steps:

1. It counts ticks so that it knows when the prescaler sits at 1023.
2. It points the index at seconds.
3. It drives the final tick and a seconds write of 30 in one cycle.

The clash is judged correct if seconds then read 30 rather than 31. A further 1023 ticks must leave 30. The 1024th tick after that must give 31, which shows the prescaler wrapped on the clash cycle.

// File: rtl/rtc_pkg.sv
// Package: shared index codes and select type for the indexed calendar clock.
// Assumes an 8-bit index space; any code not listed here selects no register.
package rtc_pkg;
    localparam logic [7:0] IDX_SEC    = 8'h10;
    localparam logic [7:0] IDX_MIN    = 8'h11;
    localparam logic [7:0] IDX_HOUR   = 8'h12;
    localparam logic [7:0] IDX_DOW    = 8'h13;
    localparam logic [7:0] IDX_DOM    = 8'h14;
    localparam logic [7:0] IDX_MON    = 8'h15;
    localparam logic [7:0] IDX_YEAR   = 8'h16;
    localparam logic [7:0] IDX_CTRL_A = 8'h20;
    localparam logic [7:0] IDX_CTRL_D = 8'h23;

    localparam int NUM_TIME = 7;

    // Enum order matters: value i+1 selects time field i.
    typedef enum logic [3:0] {
        SEL_NONE = 4'd0,
        SEL_SEC  = 4'd1,
        SEL_MIN  = 4'd2,
        SEL_HOUR = 4'd3,
        SEL_DOW  = 4'd4,
        SEL_DOM  = 4'd5,
        SEL_MON  = 4'd6,
        SEL_YEAR = 4'd7,
        SEL_CTRL = 4'd8
    } rtc_sel_e;
endpackage

// File: rtl/rtc_index_decode.sv
// Module: maps the latched index byte onto a register select.
// Purely combinational; assumes the caller holds the index stable in a register.
module rtc_index_decode
    import rtc_pkg::*;
(
    input  logic [7:0] idx,
    output rtc_sel_e   sel
);
    // Decode the index byte; control registers share one select.
    always_comb begin
        unique case (idx)
            IDX_SEC:  sel = SEL_SEC;
            IDX_MIN:  sel = SEL_MIN;
            IDX_HOUR: sel = SEL_HOUR;
            IDX_DOW:  sel = SEL_DOW;
            IDX_DOM:  sel = SEL_DOM;
            IDX_MON:  sel = SEL_MON;
            IDX_YEAR: sel = SEL_YEAR;
            default:  sel = (idx >= IDX_CTRL_A && idx <= IDX_CTRL_D) ? SEL_CTRL : SEL_NONE;
        endcase
    end
endmodule

// File: rtl/rtc_prescaler.sv
// Module: counts periodic ticks modulo DIV, flags the wrapping tick and
// registers a one-cycle interrupt per tick.
// Assumes tick is a synchronous single-cycle strobe; a tick held high counts every cycle.
module rtc_prescaler #(
    parameter int DIV = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    output logic [$clog2(DIV)-1:0]  cnt,
    output logic                    adv,
    output logic                    irq
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    // The wrapping tick is the one that finds the count at its last value.
    assign adv = tick && (cnt == LAST);

    // Tick counter, wrapping at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Interrupt pulse one cycle after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tick;
    end
endmodule

// File: rtl/rtc_time_regs.sv
// Module: storage for the seven time fields, with the month and year port
// offsets and the seconds rollover.
// Assumes wr is already qualified by the data-port strobe; a write beats a seconds advance.
module rtc_time_regs
    import rtc_pkg::*;
#(
    parameter int SEC_MAX  = 59,
    parameter int YEAR_OFS = 52
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  rtc_sel_e                     sel,
    input  logic [7:0]                   wdata,
    input  logic                         adv,
    output logic [NUM_TIME-1:0][7:0]     fld_q,
    output logic [7:0]                   rd_val
);
    localparam logic [7:0] SEC_TOP  = 8'(SEC_MAX);
    localparam logic [7:0] YOFS     = 8'(YEAR_OFS);
    localparam int         MON_POS  = int'(SEL_MON) - 1;
    localparam int         YEAR_POS = int'(SEL_YEAR) - 1;

    logic [7:0] sec_next;

    // Next seconds value on an advance: count up, or roll to zero at the top.
    always_comb sec_next = (fld_q[0] >= SEC_TOP) ? 8'd0 : fld_q[0] + 8'd1;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_fld
        logic [7:0] wr_val;

        // Convert a port byte into the stored form of this field.
        if (i == MON_POS) begin : g_mon
            assign wr_val = wdata - 8'd1;
        end else if (i == YEAR_POS) begin : g_year
            assign wr_val = wdata + YOFS;
        end else begin : g_raw
            assign wr_val = wdata;
        end

        // Field register: a port write wins, else seconds advance on the prescaler wrap.
        if (i == 0) begin : g_sec
            always_ff @(posedge clk) begin
                if (!rst_n)                          fld_q[i] <= 8'd0;
                else if (wr && sel == rtc_sel_e'(i + 1)) fld_q[i] <= wr_val;
                else if (adv)                        fld_q[i] <= sec_next;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)                          fld_q[i] <= 8'd0;
                else if (wr && sel == rtc_sel_e'(i + 1)) fld_q[i] <= wr_val;
            end
        end
    end

    // Read mux: undo the stored offsets; the control and undecoded selects read zero.
    always_comb begin
        unique case (sel)
            SEL_SEC:  rd_val = fld_q[0];
            SEL_MIN:  rd_val = fld_q[1];
            SEL_HOUR: rd_val = fld_q[2];
            SEL_DOW:  rd_val = fld_q[3];
            SEL_DOM:  rd_val = fld_q[4];
            SEL_MON:  rd_val = fld_q[MON_POS] + 8'd1;
            SEL_YEAR: rd_val = fld_q[YEAR_POS] - YOFS;
            default:  rd_val = 8'd0;
        endcase
    end
endmodule

// File: rtl/rtc_indexed_regs.sv
// Module: top of the indexed-port calendar clock. Holds the index register
// and the sticky error flag, and ties together the decode, prescaler and field storage.
// Assumes the port strobes are synchronous and single-cycle; index and data use one write bus.
module rtc_indexed_regs
    import rtc_pkg::*;
#(
    parameter int TICK_DIV = 1024,
    parameter int SEC_MAX  = 59,
    parameter int YEAR_OFS = 52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       err
);
    localparam int CNT_W = $clog2(TICK_DIV);

    logic [7:0]                idx_q;
    rtc_sel_e                  sel;
    logic [CNT_W-1:0]          pre_cnt;
    logic                      sec_adv;
    logic [NUM_TIME-1:0][7:0]  fld_q;
    logic [7:0]                rd_val;

    // Index register, loaded from the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= 8'h00;
        else if (idx_wr) idx_q <= wdata;
    end

    // Sticky error flag for any data-port access at an undecoded index.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      err <= 1'b0;
        else if ((data_rd || data_wr) && sel == SEL_NONE) err <= 1'b1;
    end

    rtc_index_decode u_dec (
        .idx (idx_q),
        .sel (sel)
    );

    rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (pre_cnt),
        .adv   (sec_adv),
        .irq   (irq)
    );

    rtc_time_regs #(.SEC_MAX(SEC_MAX), .YEAR_OFS(YEAR_OFS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (data_wr),
        .sel    (sel),
        .wdata  (wdata),
        .adv    (sec_adv),
        .fld_q  (fld_q),
        .rd_val (rd_val)
    );

    // Read data is driven only while the read strobe is high.
    assign rdata = data_rd ? rd_val : 8'h00;
endmodule

// File: rtl/rtc_indexed_regs_chk.sv
// Checker: properties of the calendar clock, bound to the top module.
// Assumes it sees the internal prescaler count, select and field storage through the bind.
module rtc_indexed_regs_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int SEC_MAX = 59
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic                        data_wr,
    input logic                        data_rd,
    input logic [7:0]                  wdata,
    input logic [7:0]                  rdata,
    input logic                        irq,
    input logic                        err,
    input rtc_sel_e                    sel,
    input logic [CNT_W-1:0]            pre_cnt,
    input logic [NUM_TIME-1:0][7:0]    fld_q
);
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> irq);                                                   // R2
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));                                            // R2
    AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pre_cnt == CNT_W'($past(pre_cnt) + 1'b1));              // R2
    AST_SEC_ONLY_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fld_q[0]) && !$past(data_wr && sel == SEL_SEC)) |->
        fld_q[0] == (($past(fld_q[0]) >= 8'(SEC_MAX)) ? 8'd0 : $past(fld_q[0]) + 8'd1)); // R3
    AST_SEC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel == SEL_SEC) |=> fld_q[0] == $past(wdata));       // R10
    AST_CTRL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel == SEL_CTRL) |=> $stable(fld_q[NUM_TIME-1:1]));  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);                                                    // R8
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |-> rdata == 8'h00);                                    // R11
endmodule

bind rtc_indexed_regs rtc_indexed_regs_chk #(.CNT_W(CNT_W), .SEC_MAX(SEC_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .err     (err),
    .sel     (sel),
    .pre_cnt (pre_cnt),
    .fld_q   (fld_q)
);

// File: tb/test_rtc_indexed_regs.sv
// Directed bench for the indexed-port calendar clock; one task per scenario.
module test_rtc_indexed_regs;
    localparam time CLK_HALF = 10ns;
    localparam int  WATCHDOG = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       idx_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       err;

    int n_cmp = 0;
    int n_bad = 0;
    int ticks_mod = 0;   // bench model of the prescaler count
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    rtc_indexed_regs i_rtc_indexed_regs (
        .clk (clk), .rst_n (rst_n), .tick (tick), .idx_wr (idx_wr),
        .data_wr (data_wr), .data_rd (data_rd), .wdata (wdata),
        .rdata (rdata), .irq (irq), .err (err)
    );

    // Compare one value and log a mismatch.
    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk); data_rd = 1'b1;
        #5ns v = rdata;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic put(input logic [7:0] idx, input logic [7:0] v);
        wr_idx(idx); wr_data(v);
    endtask

    task automatic get(input logic [7:0] idx, output logic [7:0] v);
        wr_idx(idx); rd_data(v);
    endtask

    // Hold tick high for n consecutive cycles.
    task automatic run_ticks(input int n);
        if (n <= 0) return;
        @(negedge clk); tick = 1'b1;
        for (int k = 1; k < n; k++) @(negedge clk);
        @(negedge clk); tick = 1'b0;
        ticks_mod = (ticks_mod + n) % 1024;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R11 idle rdata", rdata, 8'h00);
        check("R2 irq at reset", {7'd0, irq}, 8'd0);
        check("R8 err at reset", {7'd0, err}, 8'd0);
        get(8'h10, v); check("R4 sec reset", v, 8'h00);
        get(8'h15, v); check("R5 month reset reads 1", v, 8'h01);
        get(8'h16, v); check("R6 year reset reads 0xCC", v, 8'hCC);
    endtask

    task automatic t_fields;
        logic [7:0] v;
        put(8'h11, 8'd45); put(8'h12, 8'd23); put(8'h13, 8'd6);
        get(8'h11, v); check("R4 minutes", v, 8'd45);
        get(8'h12, v); check("R4 hour", v, 8'd23);
        get(8'h13, v); check("R1 R4 day of week", v, 8'd6);
        put(8'h15, 8'd12); get(8'h15, v); check("R5 month 12", v, 8'd12);
        put(8'h15, 8'd1);  get(8'h15, v); check("R5 month 1", v, 8'd1);
        put(8'h16, 8'd25); get(8'h16, v); check("R6 year 25", v, 8'd25);
        put(8'h16, 8'd210); get(8'h16, v); check("R6 year 210 wraps", v, 8'd210);
    endtask

    task automatic t_dom;
        logic [7:0] v;
        put(8'h14, 8'd17); put(8'h15, 8'd5);
        get(8'h14, v); check("R9 day of month alone", v, 8'd17);
        get(8'h15, v); check("R9 month beside it", v, 8'd5);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        for (int c = 0; c < 4; c++) begin
            put(8'h20 + 8'(c), 8'hFF);
            rd_data(v); check("R7 control reads zero", v, 8'h00);
        end
        get(8'h11, v); check("R7 minutes untouched", v, 8'd45);
        get(8'h14, v); check("R7 dom untouched", v, 8'd17);
        get(8'h16, v); check("R7 year untouched", v, 8'd210);
        check("R7 no error", {7'd0, err}, 8'd0);
    endtask

    task automatic t_irq;
        @(negedge clk); check("R2 irq idle", {7'd0, irq}, 8'd0);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        #1ns check("R2 irq pulse", {7'd0, irq}, 8'd1);
        @(negedge clk);
        #1ns check("R2 irq single cycle", {7'd0, irq}, 8'd0);
        ticks_mod = (ticks_mod + 1) % 1024;
    endtask

    task automatic t_seconds;
        logic [7:0] v;
        put(8'h10, 8'd7);
        run_ticks(1023 - ticks_mod);
        get(8'h10, v); check("R3 no advance before wrap", v, 8'd7);
        run_ticks(1);
        get(8'h10, v); check("R3 advance on wrap", v, 8'd8);
        put(8'h10, 8'd59);
        run_ticks(1024);
        get(8'h10, v); check("R3 59 rolls to 0", v, 8'd0);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        wr_idx(8'h10);
        run_ticks(1023 - ticks_mod);
        @(negedge clk); tick = 1'b1; data_wr = 1'b1; wdata = 8'd30;
        @(negedge clk); tick = 1'b0; data_wr = 1'b0;
        ticks_mod = 0;
        rd_data(v); check("R10 write beats advance", v, 8'd30);
        run_ticks(1023);
        rd_data(v); check("R10 prescaler wrapped on clash", v, 8'd30);
        run_ticks(1);
        rd_data(v); check("R10 next advance", v, 8'd31);
    endtask

    task automatic t_undecoded;
        logic [7:0] v;
        get(8'h00, v); check("R8 undecoded read zero", v, 8'h00);
        #1ns check("R8 err set", {7'd0, err}, 8'd1);
        put(8'h7F, 8'h55);
        get(8'h11, v); check("R8 write changed nothing", v, 8'd45);
        check("R8 err sticky", {7'd0, err}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_dom();
        t_ctrl();
        t_irq();
        t_seconds();
        t_collision();
        t_undecoded();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule